// File: doc/BRIEF.md
# Register-Mapped SPI Master

A serial peripheral interface master that a host programs through a small 32-bit register bus. The host picks a clock divider, a word width from 2 to 16 bits, the clock polarity and phase, the bit order and an internal loopback path. It then queues words in an 8-entry transmit FIFO. The block shifts each word out on `mosi`, shifts a word of the same width in from `miso`, and places that word in an 8-entry receive FIFO. Reading the receive register takes the oldest entry out.

Chip select is not part of the block. Software drives it from a general-purpose pin around each transfer. An interrupt output tells the host that everything it queued has left the shifter.

The bus uses word addressing. `addr` carries byte-offset bits [4:2]. The registers sit at these byte offsets: divider 0x00, transmit 0x04, receive 0x08, configuration 0x0C, interrupt enable 0x10. Offset 0x18 and the other unused slots accept writes without effect.

Top module: `spim_regbus`

## Requirements
- R1: The SCLK half period is N system clock cycles, where N is DIV[15:0] at offset 0x00 and the value 0 acts as 65536. When a transmit write finds the shifter idle and shifting enabled, the first SCLK edge comes N+1 cycles after the write cycle.
- R2: CFG[3:0] at offset 0x0C holds the word width minus one. The value 0 is treated as 2 bits. Transmit bits above the width are not sent, and received words read back zero above the width.
- R3: When CFG[4] is 1 the word is shifted most significant bit first. When CFG[4] is 0 it is shifted least significant bit first, and this applies to both directions.
- R4: The SCLK idle level equals CFG[6]. With CFG[5]=0 the first bit is on `mosi` before the first edge, bits are sampled on leading edges and change on trailing edges. With CFG[5]=1 bits change on leading edges and are sampled on trailing edges.
- R5: When CFG[10] is 1 the receiver takes its input from the outgoing `mosi` bit stream and `miso` has no effect.
- R6: Words written to offset 0x04 enter an 8-deep transmit FIFO, and a write to a full FIFO is dropped. Each transmitted word yields exactly one received word, in order. A read of offset 0x08 returns the oldest entry in bits [15:0] and removes it.
- R7: A received word that finds the receive FIFO full is discarded and sets a sticky overflow flag. The flag reads back as bit 16 of offset 0x08 and is cleared only by soft reset.
- R8: A read of offset 0x08 while the receive FIFO is empty returns the last value removed and leaves the FIFO empty.
- R9: When IEN bit 2 at offset 0x10 is 1, `irq` is high exactly while the transmit FIFO is empty and no word is being shifted.
- R10: While CFG[7] is 1 both FIFOs, the overflow flag and the shifter are cleared. Releasing CFG[7] leaves the block idle with all other configuration fields as written.
- R11: Words are taken from the transmit FIFO only while CFG[9] (enable) and CFG[8] (master) are both 1. Otherwise SCLK stays at its idle level.
- R12: Writes to offset 0x18 and to other unused offsets change nothing, and these offsets read as 0.
- R13: DIV[15:0], CFG[12:0] and IEN bit 2 read back as written. All of them reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word index (byte offset bits [4:2]) |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of the receive register removes an entry |
| rdata | output | 32 | Register read data, valid in the cycle of the read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-done interrupt |

## Verification
The assertions check several properties on every cycle. SCLK rests at its polarity level whenever no word is in flight. FIFO occupancy never exceeds the depth. The overflow flag stays set until soft reset. Soft reset empties both FIFOs and stops the shifter. No word starts while enable and master are not both set. Bit order, phase timing, width masking, loopback routing, the exact divider timing including the 65536 case, write dropping at a full FIFO and the value returned by an empty read depend on data and sequences. Only the bench's serial slave model and its random and directed scenarios can show those.

// File: rtl/spim_regbus.sv
module spim_regbus #(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);

  localparam int PW = $clog2(FIFO_DEPTH);
  localparam logic [PW:0]    FULLC = (PW+1)'(FIFO_DEPTH);
  localparam logic [DIV_W:0] WRAP  = {1'b1, {DIV_W{1'b0}}};
  localparam logic [2:0] A_DIV = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2,
                         A_CFG = 3'd3, A_IEN = 3'd4;

  logic [DIV_W-1:0] div_q;
  logic [12:0]      cfg_q;
  logic             ien_q;

  logic [15:0] txm [FIFO_DEPTH];
  logic [15:0] rxm [FIFO_DEPTH];
  logic [PW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic        ovf_q;
  logic [15:0] last_q;

  logic             busy, sclk_t, mosi_q;
  logic [DIV_W:0]   hcnt;
  logic [5:0]       edg;
  logic [4:0]       ktx, krx;
  logic [15:0]      word_q, rxw, rx_cur;

  logic unused_hi;
  assign unused_hi = ^wdata[31:16];

  wire srst = cfg_q[7];
  wire run  = cfg_q[9] & cfg_q[8];
  wire msbf = cfg_q[4];
  wire cpha = cfg_q[5];
  wire cpol = cfg_q[6];
  wire loop = cfg_q[10];

  wire [4:0]  wl    = (cfg_q[3:0] == 4'd0) ? 5'd2 : {1'b0, cfg_q[3:0]} + 5'd1;
  wire [15:0] wmask = 16'hFFFF >> (5'd16 - wl);
  wire [DIV_W:0] half = (div_q == '0) ? WRAP : {1'b0, div_q};

  wire tx_empty = (tx_wp == tx_rp);
  wire tx_full  = ((tx_wp - tx_rp) == FULLC);
  wire rx_empty = (rx_wp == rx_rp);
  wire rx_full  = ((rx_wp - rx_rp) == FULLC);

  wire tick   = busy && (hcnt == half - 1'b1);
  wire last   = (edg == ({wl, 1'b0} - 6'd1));
  wire launch = tick && (cpha ? ~edg[0] : (edg[0] && !last));
  wire samp   = tick && (cpha ? edg[0] : ~edg[0]);
  wire din    = loop ? mosi_q : miso;

  wire start   = !busy && run && !tx_empty && !srst;
  wire wr_tx   = wr_en && (addr == A_TXD) && !tx_full && !srst;
  wire rd_rx   = rd_en && (addr == A_RXD) && !rx_empty && !srst;
  wire push_rx = tick && last;

  wire [15:0] tx_head = txm[tx_rp[PW-1:0]];
  wire [15:0] rx_head = rxm[rx_rp[PW-1:0]];

  function automatic logic [3:0] bitpos(input logic m, input logic [4:0] w,
                                        input logic [4:0] k);
    return m ? 4'(w - 5'd1 - k) : 4'(k);
  endfunction

  always_comb begin
    rx_cur = rxw;
    if (samp) rx_cur[bitpos(msbf, wl, krx)] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cfg_q <= '0;
      ien_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_DIV:   div_q <= wdata[DIV_W-1:0];
        A_CFG:   cfg_q <= wdata[12:0];
        A_IEN:   ien_q <= wdata[2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tx) txm[tx_wp[PW-1:0]] <= wdata[15:0];
    if (push_rx && !rx_full) rxm[rx_wp[PW-1:0]] <= rx_cur & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      ovf_q  <= 1'b0;
      last_q <= '0;
    end else if (srst) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_tx) tx_wp <= tx_wp + 1'b1;
      if (start) tx_rp <= tx_rp + 1'b1;
      if (push_rx) begin
        if (rx_full) ovf_q <= 1'b1;
        else         rx_wp <= rx_wp + 1'b1;
      end
      if (rd_rx) begin
        rx_rp  <= rx_rp + 1'b1;
        last_q <= rx_head;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_t <= 1'b0;
      mosi_q <= 1'b0;
      hcnt   <= '0;
      edg    <= '0;
      ktx    <= '0;
      krx    <= '0;
      word_q <= '0;
      rxw    <= '0;
    end else if (srst) begin
      busy   <= 1'b0;
      sclk_t <= 1'b0;
      hcnt   <= '0;
      edg    <= '0;
      ktx    <= '0;
      krx    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk_t <= 1'b0;
      word_q <= tx_head;
      hcnt   <= '0;
      edg    <= '0;
      rxw    <= '0;
      krx    <= '0;
      if (!cpha) begin
        mosi_q <= tx_head[bitpos(msbf, wl, 5'd0)];
        ktx    <= 5'd1;
      end else begin
        ktx    <= 5'd0;
      end
    end else if (busy) begin
      if (tick) begin
        hcnt   <= '0;
        sclk_t <= ~sclk_t;
        edg    <= edg + 6'd1;
        if (launch) begin
          mosi_q <= word_q[bitpos(msbf, wl, ktx)];
          ktx    <= ktx + 5'd1;
        end
        if (samp) begin
          rxw <= rx_cur;
          krx <= krx + 5'd1;
        end
        if (last) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_DIV:   rdata = 32'(div_q);
      A_RXD:   rdata = {15'd0, ovf_q, rx_empty ? last_q : rx_head};
      A_CFG:   rdata = {19'd0, cfg_q};
      A_IEN:   rdata = {29'd0, ien_q, 2'b00};
      default: rdata = '0;
    endcase
  end

  assign sclk = cpol ^ sclk_t;
  assign mosi = mosi_q;
  assign irq  = ien_q & tx_empty & ~busy;

endmodule

// File: rtl/spim_regbus_chk.sv
module spim_regbus_chk #(
  parameter int FIFO_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sclk,
  input logic                          busy,
  input logic                          ovf,
  input logic [12:0]                   cfg,
  input logic [$clog2(FIFO_DEPTH):0]   tx_wp,
  input logic [$clog2(FIFO_DEPTH):0]   tx_rp,
  input logic [$clog2(FIFO_DEPTH):0]   rx_wp,
  input logic [$clog2(FIFO_DEPTH):0]   rx_rp
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam logic [PW:0] FULLC = (PW+1)'(FIFO_DEPTH);

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg[6]));

  a_r6_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wp - tx_rp) <= FULLC);

  a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wp - rx_rp) <= FULLC);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cfg[7]) |=> ovf);

  a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[7] |=> (tx_wp == tx_rp && rx_wp == rx_rp && !busy && !ovf));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cfg[9] && cfg[8])) |=> !busy);
endmodule

bind spim_regbus spim_regbus_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy), .ovf(ovf_q),
  .cfg(cfg_q), .tx_wp(tx_wp), .tx_rp(tx_rp), .rx_wp(rx_wp), .rx_rp(rx_rp)
);

// File: tb/spim_regbus_test.sv
`timescale 1ns/1ps
module spim_regbus_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, irq;
  int checks = 0, fails = 0;

  spim_regbus uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq));

  always #4 clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int bpos(input bit m, input int w, input int k);
    return m ? (w - 1 - k) : k;
  endfunction

  function automatic int wwidth(input int f);
    return (f == 0) ? 2 : f + 1;
  endfunction

  task automatic wait_edge(output bit ok);
    logic p; int n;
    p = sclk; n = 0; ok = 1'b1;
    do begin @(posedge clk); #1; n++; end while (sclk == p && n < 20000);
    if (sclk == p) ok = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] sw, input int w, input bit m,
                      input bit ph, output logic [15:0] got);
    int kt, ks; bit ok;
    got = '0; kt = 0; ks = 0;
    if (!ph) begin miso = sw[bpos(m, w, 0)]; kt = 1; end
    for (int e = 0; e < 2*w; e++) begin
      wait_edge(ok);
      if (!ok) begin chk(1'b0, "R4 edge missing", e, 2*w); return; end
      if (ph ? (e % 2 == 1) : (e % 2 == 0)) begin got[bpos(m, w, ks)] = mosi; ks++; end
      if (ph ? (e % 2 == 0) : (e % 2 == 1 && e != 2*w - 1)) begin
        miso = sw[bpos(m, w, kt)]; kt++;
      end
    end
  endtask

  task automatic quiet(input int cyc, input logic lvl, input string r);
    bit moved = 0;
    for (int i = 0; i < cyc; i++) begin @(posedge clk); #1; if (sclk != lvl) moved = 1; end
    chk(!moved, r, moved, 0);
  endtask

  task automatic measure(input logic [31:0] dv, input int exp);
    int n;
    wr(3'd3, 32'h80); wr(3'd3, 32'h0301);
    wr(3'd0, dv);
    wr(3'd1, 32'h1);
    n = 1;
    while (sclk == 1'b0 && n < 70000) begin @(posedge clk); #1; if (sclk == 1'b0) n++; end
    chk(n == exp, "R1 first edge delay", n, exp);
    wr(3'd3, 32'h0381); wr(3'd3, 32'h0301);
  endtask

  logic [31:0] d;
  logic [15:0] got, txw [10], sw [10];

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 0 && irq == 0, "R13 reset outputs", {sclk, irq}, 0);
    rd(3'd3, d); chk(d == 0, "R13 reset CFG", d, 0);
    rd(3'd0, d); chk(d == 0, "R13 reset DIV", d, 0);

    wr(3'd0, 32'hFFFF_1234); rd(3'd0, d); chk(d == 32'h1234, "R13 DIV readback", d, 32'h1234);
    wr(3'd3, 32'hFFFF_1C5A); rd(3'd3, d); chk(d == 32'h1C5A, "R13 CFG readback", d, 32'h1C5A);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); chk(d == 32'h4, "R13 IEN readback", d, 4);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk(d == 0, "R12 unused reads zero", d, 0);
    rd(3'd3, d); chk(d == 32'h1C5A, "R12 CFG untouched", d, 32'h1C5A);
    rd(3'd0, d); chk(d == 32'h1234, "R12 DIV untouched", d, 32'h1234);
    wr(3'd3, 32'h0); wr(3'd4, 32'h4);

    measure(32'd3, 4);

    void'($urandom(32'd20251));
    for (int it = 0; it < 14; it++) begin
      int f, w, n, dv; bit m, ph, po, lb; logic [31:0] base;
      f = 1 + int'($urandom % 15); w = wwidth(f);
      m = $urandom; ph = $urandom; po = $urandom; lb = $urandom;
      n = 1 + int'($urandom % 8); dv = 1 + int'($urandom % 4);
      base = f | (m << 4) | (ph << 5) | (po << 6) | (lb << 10) | 32'h1800;
      wr(3'd3, base | (($urandom % 2) ? 32'h200 : 32'h100));
      wr(3'd0, dv);
      for (int i = 0; i < n; i++) begin
        txw[i] = $urandom; sw[i] = $urandom; wr(3'd1, 32'(txw[i]));
      end
      quiet(20, po, "R11 held without enable and master");
      chk(irq == 0, "R9 irq low with queued words", irq, 0);
      wr(3'd3, base | 32'h300);
      for (int i = 0; i < n; i++) begin
        logic [15:0] mk; mk = 16'hFFFF >> (16 - w);
        xfer(sw[i], w, m, ph, got);
        chk(got == (txw[i] & mk), lb ? "R5 R3 mosi word" : "R2 R3 R4 mosi word",
            got, txw[i] & mk);
      end
      #1 chk(irq == 1, "R9 irq after drain", irq, 1);
      for (int i = 0; i < n; i++) begin
        logic [15:0] mk, ex; mk = 16'hFFFF >> (16 - w);
        ex = lb ? (txw[i] & mk) : (sw[i] & mk);
        rd(3'd2, d);
        chk(d == {15'd0, 1'b0, ex}, lb ? "R5 loopback rx word" : "R6 R4 rx word", d, ex);
      end
      rd(3'd2, d);
      begin
        logic [15:0] mk, ex; mk = 16'hFFFF >> (16 - w);
        ex = lb ? (txw[n-1] & mk) : (sw[n-1] & mk);
        chk(d == {16'd0, ex}, "R8 empty read repeats last", d, ex);
      end
    end

    wr(3'd3, 32'h1817); wr(3'd0, 32'd1);
    for (int i = 0; i < 10; i++) begin txw[i] = 16'h10 + 16'(i); sw[i] = 16'hA0 + 16'(i); wr(3'd1, 32'(txw[i])); end
    wr(3'd3, 32'h1B17);
    for (int i = 0; i < 8; i++) begin
      xfer(sw[i], 8, 1'b1, 1'b0, got);
      chk(got == txw[i], "R6 mosi word", got, txw[i]);
    end
    quiet(30, 1'b0, "R6 words beyond full dropped");
    chk(irq == 1, "R9 irq idle after full burst", irq, 1);
    wr(3'd1, 32'h77);
    xfer(16'h55, 8, 1'b1, 1'b0, got);
    for (int i = 0; i < 8; i++) begin
      rd(3'd2, d);
      chk(d == {15'd0, 1'b1, sw[i]}, "R7 overflow flag and kept data", d, {15'd0, 1'b1, sw[i]});
    end
    rd(3'd2, d); chk(d == {15'd0, 1'b1, sw[7]}, "R8 empty read after overflow", d, {15'd0, 1'b1, sw[7]});

    wr(3'd3, 32'h1817);
    for (int i = 0; i < 3; i++) wr(3'd1, 32'h33);
    wr(3'd3, 32'h1897); wr(3'd3, 32'h1817);
    rd(3'd3, d); chk(d == 32'h1817, "R10 config kept", d, 32'h1817);
    rd(3'd2, d); chk(d[16] == 0, "R10 overflow cleared", d[16], 0);
    wr(3'd3, 32'h1B17);
    quiet(40, 1'b0, "R10 transmit FIFO flushed");
    chk(irq == 1, "R10 irq idle after flush", irq, 1);

    wr(3'd3, 32'h1810); wr(3'd0, 32'd2); wr(3'd1, 32'hFFFE);
    wr(3'd3, 32'h1B10);
    xfer(16'h1, 2, 1'b1, 1'b0, got);
    chk(got == 16'h2, "R2 zero field is two bits", got, 2);
    quiet(20, 1'b0, "R2 only four edges");
    rd(3'd2, d); chk(d == 32'h1, "R2 rx width two", d, 1);

    measure(32'd0, 65537);

    summary();
    $finish;
  end
endmodule